// File: doc/BRIEF.md
# Periodic Peak Magnitude Detector

This block watches a stream of signed converter samples and reports the largest absolute magnitude seen in each measurement window. A window is a programmable number of accepted samples. A down-counting timer marks where each window ends. When a window closes, the peak found in it is copied into a 20-bit result register and a one-cycle valid pulse is raised. The next window opens with the very next accepted sample, so there is no gap between windows.

The tracker is never cleared to zero. The first sample of each window loads it directly, and every later sample in that window replaces it only when the new magnitude is larger. Software or a gain-control loop reads the result after each pulse. The running peak itself is not visible from outside the block.

Top module: `peak_window_monitor`

## Requirements
- R1: While `rst_n` is low, and after it is released, `result` reads 0 and `result_valid` reads 0 until the first window completes.
- R2: A sample is a 13-bit two's-complement code. Its magnitude is its absolute value, except that the code 0x1000 (-4096) saturates to 4095.
- R3: A window spans `period` accepted samples. A `period` value below 128, including 0, is treated as 128.
- R4: The reported peak is the largest magnitude among all samples of the window, including the first sample and the last sample.
- R5: The first sample of a window seeds the tracker directly. No value from an earlier window can appear in a later window's result.
- R6: Windows run back to back: the accepted sample after the closing sample of one window is the first sample of the next.
- R7: `result_valid` is high for exactly one cycle, in the cycle after the clock edge that accepted a window's final sample. `result` takes the new peak, zero-extended to 20 bits, in that same cycle and holds it at all other times.
- R8: A cycle with `smp_valid` low is ignored: it does not advance the window count and does not affect the peak.
- R9: While `enable` is low, samples are ignored, the partial window is discarded and `result` holds its value. After `enable` rises, a fresh window starts with the next accepted sample. `period` is read at the first sample of every window, so a change made mid-window applies from the next window onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs the measurement; low abandons the current window |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | 13 | Signed two's-complement sample |
| period | input | 24 | Window length in accepted samples (minimum 128) |
| result | output | 20 | Peak magnitude of the last completed window, zero-extended |
| result_valid | output | 1 | One-cycle pulse when `result` updates |

## Verification
The main sweep feeds every one of the 8192 sample codes once, 128 consecutive codes per window. Each window has a known maximum, which confirms the magnitude rule, including saturation of the most negative code, and shows that back-to-back windows neither lose nor share samples. Directed windows place the largest value first, last, or only in an earlier window, which separates correct seeding from a tracker that is cleared or carried over. Further patterns insert invalid cycles that carry large values, use short and zero periods, change the period mid-window, and drop `enable` during a window. These check counting, clamping and restart.

// File: rtl/pkm_pkg.sv
package pkm_pkg;

  // Raise a requested window length to the legal minimum.
  function automatic logic [31:0] clamp_len(input logic [31:0] req,
                                             input logic [31:0] floor_len);
    return (req < floor_len) ? floor_len : req;
  endfunction

endpackage

// File: rtl/pkm_magnitude.sv
module pkm_magnitude #(
  parameter int SAMPLE_W = 13
) (
  input  logic [SAMPLE_W-1:0] code,
  output logic [SAMPLE_W-1:0] mag
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MAX_POS  = {1'b0, {(SAMPLE_W-1){1'b1}}};

  // Absolute value with the single unrepresentable case saturated.
  function automatic logic [SAMPLE_W-1:0] abs_sat(input logic [SAMPLE_W-1:0] c);
    if (c == MOST_NEG)    return MAX_POS;
    else if (c[SAMPLE_W-1]) return (~c) + 1'b1;
    else                  return c;
  endfunction

  assign mag = abs_sat(code);
endmodule

// File: rtl/pkm_period_timer.sv
module pkm_period_timer #(
  parameter int PERIOD_W   = 24,
  parameter int MIN_PERIOD = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  output logic [PERIOD_W-1:0] cnt_q,
  output logic                win_first,
  output logic                win_end
);
  import pkm_pkg::*;

  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] load_val;
  logic [PERIOD_W-1:0] cnt_eff;
  logic                step;

  // A zero count means "no window open": the next accepted sample opens one.
  assign load_val  = PERIOD_W'(clamp_len(32'(period), 32'(MIN_PERIOD)));
  assign win_first = (cnt_q == '0);
  assign cnt_eff   = win_first ? load_val : cnt_q;
  assign step      = enable && tick;
  assign win_end   = step && (cnt_eff == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!enable) cnt_q <= '0;
    else if (tick)    cnt_q <= win_end ? '0 : (cnt_eff - ONE);
  end
endmodule

// File: rtl/pkm_peak_tracker.sv
module pkm_peak_tracker #(
  parameter int MAG_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             seed,
  input  logic [MAG_W-1:0] mag,
  output logic [MAG_W-1:0] peak_q,
  output logic [MAG_W-1:0] peak_next
);
  function automatic logic [MAG_W-1:0] keep_larger(input logic [MAG_W-1:0] a,
                                                   input logic [MAG_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  assign peak_next = seed ? mag : keep_larger(mag, peak_q);

  always_ff @(posedge clk) begin
    if (!rst_n)    peak_q <= '0;
    else if (step) peak_q <= peak_next;
  end
endmodule

// File: rtl/peak_window_monitor.sv
module peak_window_monitor #(
  parameter int SAMPLE_W   = 13,
  parameter int PERIOD_W   = 24,
  parameter int RESULT_W   = 20,
  parameter int MIN_PERIOD = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic [PERIOD_W-1:0] period,
  output logic [RESULT_W-1:0] result,
  output logic                result_valid
);
  // Named internal events, also observed by the bound checker.
  logic [SAMPLE_W-1:0] mag;
  logic [PERIOD_W-1:0] cnt_q;
  logic                win_first;
  logic                win_end;
  logic [SAMPLE_W-1:0] peak_q;
  logic [SAMPLE_W-1:0] peak_next;
  logic                step;

  assign step = enable && smp_valid;

  pkm_magnitude #(.SAMPLE_W(SAMPLE_W)) u_mag (
    .code (smp_data),
    .mag  (mag)
  );

  pkm_period_timer #(.PERIOD_W(PERIOD_W), .MIN_PERIOD(MIN_PERIOD)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (smp_valid),
    .period    (period),
    .cnt_q     (cnt_q),
    .win_first (win_first),
    .win_end   (win_end)
  );

  pkm_peak_tracker #(.MAG_W(SAMPLE_W)) u_peak (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .seed      (win_first),
    .mag       (mag),
    .peak_q    (peak_q),
    .peak_next (peak_next)
  );

  // Holding register: the closing sample is folded in through peak_next.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result       <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= win_end;
      if (win_end) result <= RESULT_W'(peak_next);
    end
  end
endmodule

// File: rtl/pkm_checker.sv
module pkm_checker #(
  parameter int SAMPLE_W = 13,
  parameter int PERIOD_W = 24,
  parameter int RESULT_W = 20
) (
  input logic                clk,
  input logic                rst_n,
  input logic                enable,
  input logic                smp_valid,
  input logic [RESULT_W-1:0] result,
  input logic                result_valid,
  input logic [PERIOD_W-1:0] cnt_q,
  input logic                win_first,
  input logic                win_end,
  input logic [SAMPLE_W-1:0] mag,
  input logic [SAMPLE_W-1:0] peak_q
);
  localparam logic [RESULT_W-1:0] MAX_MAG = RESULT_W'((1 << (SAMPLE_W-1)) - 1);

  // R7: a pulse only follows an accepted sample
  assert_pulse_after_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(smp_valid && enable));

  // R7: result holds between pulses
  assert_result_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result));

  // R7: a closing window raises the pulse on the next cycle
  assert_end_gives_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> result_valid);

  // R2: the reported magnitude never exceeds the largest positive code
  assert_result_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    result <= MAX_MAG);

  // R4: inside a window the tracked peak never decreases
  assert_peak_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && smp_valid && !win_first) |=> (peak_q >= $past(peak_q)));

  // R5: the opening sample seeds the tracker
  assert_seed_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && smp_valid && win_first) |=> (peak_q == $past(mag)));

  // R9: disabling abandons the open window
  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt_q == '0));

  // R8: an idle cycle leaves the count unchanged
  assert_idle_keeps_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !smp_valid) |=> $stable(cnt_q));
endmodule

bind peak_window_monitor pkm_checker #(
  .SAMPLE_W (SAMPLE_W),
  .PERIOD_W (PERIOD_W),
  .RESULT_W (RESULT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .enable       (enable),
  .smp_valid    (smp_valid),
  .result       (result),
  .result_valid (result_valid),
  .cnt_q        (cnt_q),
  .win_first    (win_first),
  .win_end      (win_end),
  .mag          (mag),
  .peak_q       (peak_q)
);

// File: tb/sim_peak_window_monitor.sv
`timescale 1ns/1ps
module sim_peak_window_monitor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        smp_valid = 1'b0;
  logic [12:0] smp_data = '0;
  logic [23:0] period = 24'd128;
  logic [19:0] result;
  logic        result_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // Reference window state kept by the bench
  int m_cnt = 0;
  int m_target = 128;
  int m_peak = 0;
  int m_res = 0;

  always #5 clk = ~clk;

  peak_window_monitor u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .smp_valid(smp_valid),
    .smp_data(smp_data), .period(period), .result(result),
    .result_valid(result_valid)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      fails++;
      $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic int ref_mag(input int code);
    int s;
    s = code & 8191;
    if (s >= 4096) s = s - 8192;
    if (s == -4096) return 4095;
    return (s < 0) ? -s : s;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic v, input int code, input string tag);
    int exp_pulse;
    int mg;
    @(negedge clk);
    smp_valid = v;
    smp_data  = 13'(code);
    exp_pulse = 0;
    mg = ref_mag(code);
    if (!enable) m_cnt = 0;
    else if (v) begin
      if (m_cnt == 0) begin
        m_target = (period < 24'd128) ? 128 : int'(period);
        m_peak = mg;
      end else if (mg > m_peak) m_peak = mg;
      m_cnt++;
      if (m_cnt == m_target) begin
        exp_pulse = 1;
        m_res = m_peak;
        m_cnt = 0;
      end
    end
    @(posedge clk);
    #2;
    check({tag, " valid"}, int'(result_valid), exp_pulse);
    check({tag, " result"}, int'(result), m_res);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1 in reset valid", int'(result_valid), 0);
    check("R1 in reset result", int'(result), 0);
    @(negedge clk); rst_n = 1'b1; enable = 1'b1; period = 24'd128;
    @(posedge clk); #2;
    check("R1 after reset valid", int'(result_valid), 0);
    check("R1 after reset result", int'(result), 0);

    // R2 R4 R6: every code exactly once, 128 consecutive codes per window
    for (int w = 0; w < 64; w++)
      for (int i = 0; i < 128; i++)
        push(1'b1, w*128 + i, "R2 R4 R6 sweep");

    // R5: seeding and no carry-over
    for (int i = 0; i < 127; i++) push(1'b1, 10, "R5 lead");
    push(1'b1, 3000, "R4 last sample max");
    push(1'b1, 2500, "R5 first sample max");
    for (int i = 0; i < 127; i++) push(1'b1, 5, "R5 tail");
    for (int i = 0; i < 128; i++) push(1'b1, 7, "R5 no carry");
    for (int i = 0; i < 128; i++) push(1'b1, -1, "R2 negative");

    // R8: idle cycles carrying the largest code are ignored
    for (int i = 0; i < 128; i++) begin
      push(1'b0, -4096, "R8 idle");
      push(1'b1, 20, "R8 counted");
    end

    // R3: short and zero periods clamp to 128
    period = 24'd5;
    for (int i = 0; i < 128; i++) push(1'b1, i, "R3 clamp 5");
    period = 24'd0;
    for (int i = 0; i < 128; i++) push(1'b1, 128 - i, "R3 clamp 0");
    period = 24'd200;
    for (int i = 0; i < 200; i++) push(1'b1, (i == 199) ? -300 : 3, "R3 R4 period 200");

    // R9: period change mid-window applies to the next window
    period = 24'd128;
    for (int i = 0; i < 60; i++) push(1'b1, 11, "R9 old period");
    period = 24'd300;
    for (int i = 0; i < 68; i++) push(1'b1, 12, "R9 old period end");
    for (int i = 0; i < 300; i++) push(1'b1, 40 + (i % 3), "R9 new period");

    // R9: dropping enable abandons the partial window
    period = 24'd128;
    for (int i = 0; i < 50; i++) push(1'b1, 4000, "R9 partial");
    enable = 1'b0;
    for (int i = 0; i < 5; i++) push(1'b1, 4000, "R9 disabled");
    enable = 1'b1;
    for (int i = 0; i < 128; i++) push(1'b1, 33, "R9 restart");

    @(negedge clk); smp_valid = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule